// File: doc/BRIEF.md
# Integer ALU with Overflow-Corrected Sign Flag

This block is a 32-bit integer arithmetic and logic unit that also generates four status flags: negative (N), zero (Z), overflow (V) and carry/borrow (C). The N flag differs from the usual convention. After an arithmetic operation, N gives the sign that the result would have had with unlimited precision. It does not give the sign bit that ends up in the truncated result. Because of this, a signed "less than" test reads N alone and never has to combine N with V.

Each accepted operation (in_valid high) updates the flag register on the next clock edge. Every operation except compare also writes the result register, so the result has one cycle of latency. A combinational condition evaluator reads the registered flags and answers one of sixteen condition selectors: signed, unsigned, overflow, always and never.

Top module: `sgnfix_alu`

## Requirements
- R1: Opcode encoding on `op`: 0 add (a+b), 1 subtract (a-b), 2 negate (0-a), 3 absolute value of a, 4 compare, 5 AND, 6 OR, 7 XOR. For every opcode except compare, the truncated 32-bit result appears on `res` one cycle after the op is accepted, and `res_valid` is high for that one cycle.
- R2: For add, subtract, negate and absolute value, N equals bit 31 of the result XOR V. For example, 0x80000000 - 0x7FFFFFFF gives 0x00000001 with N=1.
- R3: For AND, OR and XOR, N equals bit 31 of the result, and V and C are both 0.
- R4: V is set when the signed operation overflows 32 bits. For example, 0x7FFFFFFF + 1 gives 0x80000000 with N=0, Z=0, V=1, C=0.
- R5: C holds the carry out of bit 31 for add. For subtract, compare and negate, C holds the borrow (set when the unsigned minuend is below the subtrahend). Absolute value clears C.
- R6: Z is set exactly when the truncated 32-bit result is zero, whatever V is.
- R7: Compare computes a-b into the flags only. `res` keeps its value, `res_valid` stays low, and N is set exactly when a < b as signed numbers.
- R8: The absolute value of 0x80000000 returns 0x80000000 with V=1, N=0 and C=0.
- R9: When in_valid is low, the flags and `res` hold their values, whatever is on `op`, `opa` and `opb`.
- R10: Asserting rst_n low clears `res`, `res_valid` and all four flags to 0 without waiting for a clock edge.
- R11: Signed and equality selectors on `cond_sel`: 0 always, 1 equal (Z), 2 not equal, 3 less (N), 4 greater-or-equal (!N), 5 less-or-equal (N|Z), 6 greater (!N&!Z), 13 minus (N). Selectors 3 and 13 always agree.
- R12: Unsigned, overflow and never selectors on `cond_sel`: 7 lower (C), 8 higher-or-same (!C), 9 lower-or-same (C|Z), 10 higher (!C&!Z), 11 overflow set (V), 12 overflow clear (!V), 14 and 15 never.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accepts the operation on this edge |
| op | input | 3 | Opcode |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| cond_sel | input | 4 | Condition selector |
| res | output | 32 | Registered result |
| res_valid | output | 1 | Result written on the previous accepted op |
| flag_n | output | 1 | Overflow-corrected negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Signed overflow flag |
| flag_c | output | 1 | Carry or borrow flag |
| cond_true | output | 1 | Selected condition holds on current flags |

## Verification
The hardest cases are the ones where the truncated sign bit and N disagree. That only happens on an overflowing operation, so the operands have to sit at the signed extremes. The vector table therefore drives operand pairs built around 0x7FFFFFFF and 0x80000000: add, subtract, negate and absolute value of the most negative value, and a sum that wraps to zero with every flag set. Compares between these same extremes then drive the condition evaluator, checking that "less" and "minus" agree even when V is set.

// File: rtl/sgnfix_pkg.sv
package sgnfix_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_NEG = 3'd2,
    OP_ABS = 3'd3,
    OP_CMP = 3'd4,
    OP_AND = 3'd5,
    OP_OR  = 3'd6,
    OP_XOR = 3'd7
  } op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  typedef enum logic [3:0] {
    CC_ALW = 4'd0,
    CC_EQ  = 4'd1,
    CC_NE  = 4'd2,
    CC_LT  = 4'd3,
    CC_GE  = 4'd4,
    CC_LE  = 4'd5,
    CC_GT  = 4'd6,
    CC_LO  = 4'd7,
    CC_HS  = 4'd8,
    CC_LS  = 4'd9,
    CC_HI  = 4'd10,
    CC_VS  = 4'd11,
    CC_VC  = 4'd12,
    CC_MI  = 4'd13,
    CC_NV0 = 4'd14,
    CC_NV1 = 4'd15
  } cond_e;

endpackage

// File: rtl/sgnfix_arith.sv
module sgnfix_arith
  import sgnfix_pkg::*;
#(
  parameter int W = 32
) (
  input  op_e            op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   result,
  output flags_t         flags,
  output logic           writes
);

  localparam int MSB = W - 1;

  logic [W-1:0] x;
  logic [W-1:0] y;
  logic         sub;
  logic [W-1:0] y_eff;
  logic [W:0]   sum_ext;
  logic [W-1:0] sum;
  logic         cout;
  logic         ovf;
  logic         is_logic;

  // Operand steering onto the single shared adder
  always_comb begin
    x   = a;
    y   = b;
    sub = 1'b0;
    case (op)
      OP_ADD:         begin x = a;       y = b; sub = 1'b0; end
      OP_SUB, OP_CMP: begin x = a;       y = b; sub = 1'b1; end
      OP_NEG, OP_ABS: begin x = '0;      y = a; sub = 1'b1; end
      default:        begin x = a;       y = b; sub = 1'b0; end
    endcase
  end

  assign y_eff   = y ^ {W{sub}};
  assign sum_ext = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, sub};
  assign sum     = sum_ext[W-1:0];
  assign cout    = sum_ext[W];
  assign ovf     = (x[MSB] == y_eff[MSB]) && (sum[MSB] != x[MSB]);
  assign is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);

  // Result and flag selection
  always_comb begin
    result  = sum;
    flags.v = ovf;
    flags.c = sub ? ~cout : cout;
    case (op)
      OP_ABS: begin
        result  = a[MSB] ? sum : a;
        flags.v = a[MSB] & ovf;
        flags.c = 1'b0;
      end
      OP_AND: begin result = a & b; flags.v = 1'b0; flags.c = 1'b0; end
      OP_OR:  begin result = a | b; flags.v = 1'b0; flags.c = 1'b0; end
      OP_XOR: begin result = a ^ b; flags.v = 1'b0; flags.c = 1'b0; end
      default: ;
    endcase
    flags.z = (result == '0);
    flags.n = is_logic ? result[MSB] : (result[MSB] ^ flags.v);
  end

  assign writes = (op != OP_CMP);

endmodule

// File: rtl/sgnfix_cond.sv
module sgnfix_cond
  import sgnfix_pkg::*;
(
  input  flags_t      flags,
  input  logic [3:0]  sel,
  output logic        take
);

  always_comb begin
    case (cond_e'(sel))
      CC_ALW: take = 1'b1;
      CC_EQ:  take = flags.z;
      CC_NE:  take = ~flags.z;
      CC_LT:  take = flags.n;
      CC_GE:  take = ~flags.n;
      CC_LE:  take = flags.n | flags.z;
      CC_GT:  take = ~flags.n & ~flags.z;
      CC_LO:  take = flags.c;
      CC_HS:  take = ~flags.c;
      CC_LS:  take = flags.c | flags.z;
      CC_HI:  take = ~flags.c & ~flags.z;
      CC_VS:  take = flags.v;
      CC_VC:  take = ~flags.v;
      CC_MI:  take = flags.n;
      default: take = 1'b0;
    endcase
  end

endmodule

// File: rtl/sgnfix_alu.sv
module sgnfix_alu
  import sgnfix_pkg::*;
#(
  parameter int W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    op,
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  input  logic [3:0]    cond_sel,
  output logic [W-1:0]  res,
  output logic          res_valid,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_v,
  output logic          flag_c,
  output logic          cond_true
);

  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  op_e          op_dec;
  logic [W-1:0] new_res;
  flags_t       new_flags;
  logic         new_wr;

  flags_t       flags_q, flags_d;
  logic [W-1:0] res_q,   res_d;
  logic         rv_q,    rv_d;

  assign op_dec = op_e'(op);

  sgnfix_arith #(.W(W)) u_arith (
    .op     (op_dec),
    .a      (opa),
    .b      (opb),
    .result (new_res),
    .flags  (new_flags),
    .writes (new_wr)
  );

  sgnfix_cond u_cond (
    .flags (flags_q),
    .sel   (cond_sel),
    .take  (cond_true)
  );

  // Next-state
  always_comb begin
    flags_d = flags_q;
    res_d   = res_q;
    rv_d    = 1'b0;
    if (in_valid) begin
      flags_d = new_flags;
      if (new_wr) begin
        res_d = new_res;
        rv_d  = 1'b1;
      end
    end
  end

  // State
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      res_q   <= '0;
      rv_q    <= 1'b0;
    end else begin
      flags_q <= flags_d;
      res_q   <= res_d;
      rv_q    <= rv_d;
    end
  end

  assign res       = res_q;
  assign res_valid = rv_q;
  assign flag_n    = flags_q.n;
  assign flag_z    = flags_q.z;
  assign flag_v    = flags_q.v;
  assign flag_c    = flags_q.c;

  // R9
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> ($stable({flag_n, flag_z, flag_v, flag_c}) && $stable(res)));

  // R3
  logic_vc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == OP_AND || op == OP_OR || op == OP_XOR)) |=> (!flag_v && !flag_c));

  // R7
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_CMP) |=> ($stable(res) && !res_valid));

  // R7
  cmp_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_CMP) |=> (flag_n == ($signed($past(opa)) < $signed($past(opb)))));

  // R2
  add_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_ADD) |=>
      (flag_n == (($signed({$past(opa[W-1]), $past(opa)}) +
                   $signed({$past(opb[W-1]), $past(opb)})) < 0)));

  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op != OP_CMP) |=> (flag_z == (res == '0)));

  // R8
  abs_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_ABS && opa == SMIN) |=> (flag_v && !flag_n && !flag_c && res == SMIN));

endmodule

// File: tb/sgnfix_alu_bench.sv
module sgnfix_alu_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] r;
    logic [3:0]  nzvc;
  } vec_t;

  // op, a, b, expected result, expected {N,Z,V,C}
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 4'b0010}, // R4 R2
    '{3'd1, 32'h80000000, 32'h7FFFFFFF, 32'h00000001, 4'b1010}, // R2
    '{3'd0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 4'b0101}, // R5 R6
    '{3'd1, 32'h00000005, 32'h00000007, 32'hFFFFFFFE, 4'b1001}, // R5
    '{3'd2, 32'h80000000, 32'h00000000, 32'h80000000, 4'b0011}, // R2 R4
    '{3'd2, 32'h00000005, 32'h00000000, 32'hFFFFFFFB, 4'b1001},
    '{3'd2, 32'h00000000, 32'h00000000, 32'h00000000, 4'b0100},
    '{3'd3, 32'hFFFFFFF6, 32'h00000000, 32'h0000000A, 4'b0000},
    '{3'd3, 32'h80000000, 32'h00000000, 32'h80000000, 4'b0010}, // R8
    '{3'd5, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 4'b1000}, // R3
    '{3'd6, 32'h00000000, 32'h00000000, 32'h00000000, 4'b0100},
    '{3'd7, 32'h80000001, 32'h00000001, 32'h80000000, 4'b1000},
    '{3'd0, 32'h80000000, 32'h80000000, 32'h00000000, 4'b1111}, // R6 with V
    '{3'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h80000000, 4'b0011},
    '{3'd3, 32'h00000007, 32'h00000000, 32'h00000007, 4'b0000}
  };

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op;
  logic [31:0] opa;
  logic [31:0] opb;
  logic [3:0]  cond_sel;
  logic [31:0] res;
  logic        res_valid;
  logic        flag_n, flag_z, flag_v, flag_c;
  logic        cond_true;

  int n_chk;
  int n_fail;

  sgnfix_alu u_sgnfix_alu (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .opa       (opa),
    .opb       (opb),
    .cond_sel  (cond_sel),
    .res       (res),
    .res_valid (res_valid),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_v    (flag_v),
    .flag_c    (flag_c),
    .cond_true (cond_true)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_flags(input string tag, input logic [3:0] exp);
    check(tag, {28'd0, flag_n, flag_z, flag_v, flag_c}, {28'd0, exp});
  endtask

  task automatic do_op(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op = o; opa = a; opb = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic cond_exp(input int sel, input logic [3:0] f);
    logic n, z, v, c;
    {n, z, v, c} = f;
    case (sel)
      0: return 1'b1;
      1: return z;
      2: return !z;
      3: return n;
      4: return !n;
      5: return n | z;
      6: return !n & !z;
      7: return c;
      8: return !c;
      9: return c | z;
      10: return !c & !z;
      11: return v;
      12: return !v;
      13: return n;
      default: return 1'b0;
    endcase
  endfunction

  task automatic sweep_cond();
    logic [3:0] f;
    f = {flag_n, flag_z, flag_v, flag_c};
    for (int s = 0; s < 16; s++) begin
      cond_sel = 4'(s);
      #1;
      if (s <= 6 || s == 13) check("R11 cond", {31'd0, cond_true}, {31'd0, cond_exp(s, f)});
      else                   check("R12 cond", {31'd0, cond_true}, {31'd0, cond_exp(s, f)});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; in_valid = 1'b0; op = 3'd0; opa = '0; opb = '0; cond_sel = 4'd0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 res", res, 32'h0);
    check("R10 res_valid", {31'd0, res_valid}, 32'h0);
    check_flags("R10 flags", 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table: R1 result, R2/R3 sign, R6 zero, R4 overflow, R5 carry
    for (int i = 0; i < NVEC; i++) begin
      do_op(VECS[i].op, VECS[i].a, VECS[i].b);
      if (VECS[i].op == 3'd3 && VECS[i].a == 32'h80000000) begin
        check("R8 abs min res", res, VECS[i].r);
        check_flags("R8 abs min flags", VECS[i].nzvc);
      end else begin
        check("R1 result", res, VECS[i].r);
        check("R1 res_valid", {31'd0, res_valid}, 32'h1);
        if (VECS[i].op >= 3'd5) check("R3 N", {31'd0, flag_n}, {31'd0, VECS[i].nzvc[3]});
        else                    check("R2 N", {31'd0, flag_n}, {31'd0, VECS[i].nzvc[3]});
        check("R6 Z", {31'd0, flag_z}, {31'd0, VECS[i].nzvc[2]});
        check("R4 V", {31'd0, flag_v}, {31'd0, VECS[i].nzvc[1]});
        check("R5 C", {31'd0, flag_c}, {31'd0, VECS[i].nzvc[0]});
      end
    end

    // R9 hold when in_valid is low
    do_op(3'd0, 32'h80000000, 32'h80000000);
    check_flags("R9 setup flags", 4'b1111);
    op = 3'd5; opa = 32'hFFFFFFFF; opb = 32'hFFFFFFFF;
    repeat (3) @(negedge clk);
    check_flags("R9 flags held", 4'b1111);
    check("R9 res held", res, 32'h0);
    check("R9 res_valid low", {31'd0, res_valid}, 32'h0);

    // R7 compare: flags only
    do_op(3'd0, 32'd10, 32'd20);
    check("R1 add", res, 32'd30);
    do_op(3'd4, 32'd3, 32'd9);
    check("R7 cmp keeps res", res, 32'd30);
    check("R7 cmp res_valid", {31'd0, res_valid}, 32'h0);
    check_flags("R7 cmp 3,9 flags", 4'b1001);
    sweep_cond();

    do_op(3'd4, 32'h80000000, 32'h7FFFFFFF);
    check_flags("R7 cmp min,max flags", 4'b1010);
    check("R7 cmp keeps res", res, 32'd30);
    cond_sel = 4'd3; #1;
    check("R11 signed less with V", {31'd0, cond_true}, 32'h1);
    sweep_cond();

    do_op(3'd4, 32'd9, 32'd9);
    check_flags("R7 cmp equal flags", 4'b0100);
    sweep_cond();

    do_op(3'd4, 32'h7FFFFFFF, 32'h80000000);
    check_flags("R7 cmp max,min flags", 4'b0011);
    sweep_cond();

    // R10 asynchronous reset mid-run
    do_op(3'd0, 32'h80000000, 32'h80000000);
    #2;
    rst_n = 1'b0;
    #1;
    check("R10 async res", res, 32'h0);
    check_flags("R10 async flags", 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_flags("R10 after release", 4'b0000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule